// File: doc/BRIEF.md
# Sample-Only Boundary Test Port

This block is the serial test access port of a memory device. A standard
sixteen-state test controller, stepped by the test clock and the mode select
line, routes the serial data input through one of four shift paths: a
three-bit instruction register, a one-bit bypass stage, a 32-bit device
identification register, or a boundary chain whose stages capture a
parameterised vector of pad input levels.

The boundary chain only observes the pads. Its capture loads the levels seen
on the pads, and its shift path moves them out serially. Nothing shifted in
is ever transferred to an output latch. Passing through the data-update state
therefore has no effect, and the internal-test operation is not provided. The
serial output changes on the falling edge of the test clock. An output enable
marks the two shift states, so that several devices can share one scan wire.

Top module: `jtag_sample_port`

## Requirements
- R1: With the bypass path selected, Capture-DR clears the one-bit bypass stage. Shift-DR then returns a 0 first, followed by each TDI bit delayed by exactly one shift.
- R2: With IDCODE (opcode 3'b001) active, Capture-DR loads the 32-bit constant given by parameter ID_VALUE into the identification register.
- R3: The identification and boundary registers shift towards bit 0. Bit 0 appears on TDO for the first shift, and TDI enters at the top bit.
- R4: With SAMPLE/PRELOAD (opcode 3'b100) active, Capture-DR loads pad_levels into the boundary register, with pad i in stage i, and Shift-DR shifts that register.
- R5: SAMPLE-Z (opcode 3'b010) and EXTEST (opcode 3'b000) select the boundary register in the same way as SAMPLE/PRELOAD. No pad is driven.
- R6: In Shift-IR, TDI enters the top bit of the instruction shift register and bit 0 leaves on TDO. The active instruction changes only in Update-IR or Test-Logic-Reset.
- R7: Capture-IR loads 3'b001, so the first two instruction bits read out are 1 then 0.
- R8: Update-DR changes no register. Pause-DR holds the shift position, so a shift resumed through Exit2-DR continues with the next bit.
- R9: Test-Logic-Reset makes IDCODE the active instruction. The controller enters it on trst_n low (asynchronous) or after five TCK rising edges with TMS high.
- R10: Opcode 3'b011 (the slot of the internal-test operation), the unassigned codes 3'b101 and 3'b110, and BYPASS (3'b111) all select the bypass stage.
- R11: tdo and tdo_en change on the falling edge of TCK. tdo_en is high only while the controller is in Shift-IR or Shift-DR, and tdo is 0 whenever tdo_en is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select, sampled on rising TCK |
| tdi | input | 1 | Serial test data in, sampled on rising TCK |
| pad_levels | input | NPADS | Pad input levels observed by the boundary chain |
| tdo | output | 1 | Serial test data out, updated on falling TCK |
| tdo_en | output | 1 | High while a shift state drives tdo |

## Verification
The checker assumes that TMS and TDI settle between rising TCK edges. It also assumes that pad_levels are stable across the rising edge that leaves Capture-DR, so that a sampled pad vector can be compared with the captured chain one cycle later. The bench changes TMS, TDI and pad_levels only just after a falling TCK edge and alters the pads only while the controller waits in Run-Test/Idle. Test reset is asserted only while TMS is held high, so the synchronised release always leaves the controller in Test-Logic-Reset.

// File: rtl/jtag_port_pkg.sv
package jtag_port_pkg;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SEL_DR, TS_CAP_DR, TS_SHIFT_DR, TS_EXIT1_DR, TS_PAUSE_DR, TS_EXIT2_DR, TS_UPD_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SHIFT_IR, TS_EXIT1_IR, TS_PAUSE_IR, TS_EXIT2_IR, TS_UPD_IR
  } tap_state_t;

  localparam int IR_W = 3;
  typedef logic [IR_W-1:0] opcode_t;

  localparam opcode_t OP_EXTEST   = 3'b000;
  localparam opcode_t OP_IDCODE   = 3'b001;
  localparam opcode_t OP_SAMPLE_Z = 3'b010;
  localparam opcode_t OP_SAMPLE   = 3'b100;
  localparam opcode_t OP_BYPASS   = 3'b111;
  localparam opcode_t IR_CAPTURE_PAT = 3'b001;

  typedef enum logic [1:0] {PATH_BYPASS, PATH_ID, PATH_BSCAN} dr_path_t;

  function automatic dr_path_t decode_op(opcode_t op);
    dr_path_t p;
    case (op)
      OP_IDCODE:                         p = PATH_ID;
      OP_SAMPLE, OP_SAMPLE_Z, OP_EXTEST: p = PATH_BSCAN;
      default:                           p = PATH_BYPASS;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/jtag_rst_sync.sv
module jtag_rst_sync (
  input  logic tck,
  input  logic trst_n,
  output logic rst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n = sync_q[1];
endmodule

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
  import jtag_port_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_t state
);
  tap_state_t state_d;

  always_comb begin
    state_d = state;
    case (state)
      TS_RESET:    state_d = tms ? TS_RESET    : TS_IDLE;
      TS_IDLE:     state_d = tms ? TS_SEL_DR   : TS_IDLE;
      TS_SEL_DR:   state_d = tms ? TS_SEL_IR   : TS_CAP_DR;
      TS_CAP_DR:   state_d = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
      TS_SHIFT_DR: state_d = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
      TS_EXIT1_DR: state_d = tms ? TS_UPD_DR   : TS_PAUSE_DR;
      TS_PAUSE_DR: state_d = tms ? TS_EXIT2_DR : TS_PAUSE_DR;
      TS_EXIT2_DR: state_d = tms ? TS_UPD_DR   : TS_SHIFT_DR;
      TS_UPD_DR:   state_d = tms ? TS_SEL_DR   : TS_IDLE;
      TS_SEL_IR:   state_d = tms ? TS_RESET    : TS_CAP_IR;
      TS_CAP_IR:   state_d = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
      TS_SHIFT_IR: state_d = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
      TS_EXIT1_IR: state_d = tms ? TS_UPD_IR   : TS_PAUSE_IR;
      TS_PAUSE_IR: state_d = tms ? TS_EXIT2_IR : TS_PAUSE_IR;
      TS_EXIT2_IR: state_d = tms ? TS_UPD_IR   : TS_SHIFT_IR;
      TS_UPD_IR:   state_d = tms ? TS_SEL_DR   : TS_IDLE;
      default:     state_d = TS_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= TS_RESET;
    else        state <= state_d;
  end
endmodule

// File: rtl/jtag_ir.sv
module jtag_ir
  import jtag_port_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  tap_state_t state,
  input  logic       tdi,
  output opcode_t    ir_sr,
  output opcode_t    ir_active
);
  opcode_t sr_d, act_d;
  logic    sr_en, act_en;

  always_comb begin
    sr_en  = (state == TS_CAP_IR) || (state == TS_SHIFT_IR);
    act_en = (state == TS_UPD_IR) || (state == TS_RESET);
    sr_d   = (state == TS_CAP_IR) ? IR_CAPTURE_PAT : {tdi, ir_sr[IR_W-1:1]};
    act_d  = (state == TS_RESET) ? OP_IDCODE : ir_sr;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      ir_sr     <= IR_CAPTURE_PAT;
      ir_active <= OP_IDCODE;
    end else begin
      if (sr_en)  ir_sr     <= sr_d;
      if (act_en) ir_active <= act_d;
    end
  end
endmodule

// File: rtl/jtag_dr.sv
module jtag_dr
  import jtag_port_pkg::*;
#(
  parameter int          NPADS    = 12,
  parameter logic [31:0] ID_VALUE = 32'h1B6C_A0E3
) (
  input  logic             tck,
  input  logic             rst_n,
  input  tap_state_t       state,
  input  dr_path_t         path,
  input  logic             tdi,
  input  logic [NPADS-1:0] pad_levels,
  output logic             byp_q,
  output logic [31:0]      id_sr,
  output logic [NPADS-1:0] bs_sr
);
  localparam int ID_W = 32;

  logic             cap_en, shift_en;
  logic             byp_en, id_en, bs_en;
  logic             byp_d;
  logic [ID_W-1:0]  id_d;
  logic [NPADS-1:0] bs_d, bs_shift;

  generate
    if (NPADS == 1) begin : g_bs_one
      assign bs_shift = tdi;
    end else begin : g_bs_many
      assign bs_shift = {tdi, bs_sr[NPADS-1:1]};
    end
  endgenerate

  always_comb begin
    cap_en   = (state == TS_CAP_DR);
    shift_en = (state == TS_SHIFT_DR);
    byp_en   = (cap_en || shift_en) && (path == PATH_BYPASS);
    id_en    = (cap_en || shift_en) && (path == PATH_ID);
    bs_en    = (cap_en || shift_en) && (path == PATH_BSCAN);
    byp_d    = cap_en ? 1'b0 : tdi;
    id_d     = cap_en ? ID_VALUE : {tdi, id_sr[ID_W-1:1]};
    bs_d     = cap_en ? pad_levels : bs_shift;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      byp_q <= 1'b0;
      id_sr <= '0;
      bs_sr <= '0;
    end else begin
      if (byp_en) byp_q <= byp_d;
      if (id_en)  id_sr <= id_d;
      if (bs_en)  bs_sr <= bs_d;
    end
  end
endmodule

// File: rtl/jtag_sample_port.sv
module jtag_sample_port
  import jtag_port_pkg::*;
#(
  parameter int          NPADS    = 12,
  parameter logic [31:0] ID_VALUE = 32'h1B6C_A0E3
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tms,
  input  logic             tdi,
  input  logic [NPADS-1:0] pad_levels,
  output logic             tdo,
  output logic             tdo_en
);
  logic             rst_n;
  tap_state_t       state;
  opcode_t          ir_sr, ir_active;
  dr_path_t         path;
  logic             byp_q;
  logic [31:0]      id_sr;
  logic [NPADS-1:0] bs_sr;
  logic             tdo_d, tdo_en_d;

  jtag_rst_sync u_rst (.tck(tck), .trst_n(trst_n), .rst_n(rst_n));

  jtag_tap_fsm u_fsm (.tck(tck), .rst_n(rst_n), .tms(tms), .state(state));

  jtag_ir u_ir (
    .tck(tck), .rst_n(rst_n), .state(state), .tdi(tdi),
    .ir_sr(ir_sr), .ir_active(ir_active)
  );

  assign path = decode_op(ir_active);

  jtag_dr #(.NPADS(NPADS), .ID_VALUE(ID_VALUE)) u_dr (
    .tck(tck), .rst_n(rst_n), .state(state), .path(path), .tdi(tdi),
    .pad_levels(pad_levels), .byp_q(byp_q), .id_sr(id_sr), .bs_sr(bs_sr)
  );

  always_comb begin
    tdo_en_d = (state == TS_SHIFT_IR) || (state == TS_SHIFT_DR);
    tdo_d    = 1'b0;
    if (state == TS_SHIFT_IR) begin
      tdo_d = ir_sr[0];
    end else if (state == TS_SHIFT_DR) begin
      case (path)
        PATH_ID:    tdo_d = id_sr[0];
        PATH_BSCAN: tdo_d = bs_sr[0];
        default:    tdo_d = byp_q;
      endcase
    end
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo    <= tdo_d;
      tdo_en <= tdo_en_d;
    end
  end
endmodule

// File: rtl/jtag_sample_port_chk.sv
module jtag_sample_port_chk
  import jtag_port_pkg::*;
#(
  parameter int          NPADS    = 12,
  parameter logic [31:0] ID_VALUE = 32'h1B6C_A0E3
) (
  input logic             tck,
  input logic             rst_n,
  input tap_state_t       state,
  input opcode_t          ir_sr,
  input opcode_t          ir_active,
  input dr_path_t         path,
  input logic             byp_q,
  input logic [31:0]      id_sr,
  input logic [NPADS-1:0] bs_sr,
  input logic [NPADS-1:0] pad_levels,
  input logic             tdo,
  input logic             tdo_en
);
  AST_TDOEN_SHIFT: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_en == ((state == TS_SHIFT_DR) || (state == TS_SHIFT_IR))); // R11
  AST_TDO_QUIET: assert property (@(posedge tck) disable iff (!rst_n)
    !tdo_en |-> !tdo); // R11
  AST_IR_HOLD: assert property (@(posedge tck) disable iff (!rst_n)
    !((state == TS_UPD_IR) || (state == TS_RESET)) |=> $stable(ir_active)); // R6
  AST_RESET_IDCODE: assert property (@(posedge tck) disable iff (!rst_n)
    (state == TS_RESET) |=> (ir_active == OP_IDCODE)); // R9
  AST_IR_CAPTURE: assert property (@(posedge tck) disable iff (!rst_n)
    (state == TS_CAP_IR) |=> (ir_sr == IR_CAPTURE_PAT)); // R7
  AST_ID_CAPTURE: assert property (@(posedge tck) disable iff (!rst_n)
    ((state == TS_CAP_DR) && (path == PATH_ID)) |=> (id_sr == ID_VALUE)); // R2
  AST_BS_CAPTURE: assert property (@(posedge tck) disable iff (!rst_n)
    ((state == TS_CAP_DR) && (path == PATH_BSCAN)) |=> (bs_sr == $past(pad_levels))); // R4
  AST_BYP_CAPTURE: assert property (@(posedge tck) disable iff (!rst_n)
    ((state == TS_CAP_DR) && (path == PATH_BYPASS)) |=> !byp_q); // R1
  AST_UPDR_QUIET: assert property (@(posedge tck) disable iff (!rst_n)
    (state == TS_UPD_DR) |=> ($stable(bs_sr) && $stable(id_sr) && $stable(byp_q))); // R8
endmodule

bind jtag_sample_port jtag_sample_port_chk #(.NPADS(NPADS), .ID_VALUE(ID_VALUE)) u_chk (
  .tck(tck), .rst_n(rst_n), .state(state), .ir_sr(ir_sr), .ir_active(ir_active),
  .path(path), .byp_q(byp_q), .id_sr(id_sr), .bs_sr(bs_sr),
  .pad_levels(pad_levels), .tdo(tdo), .tdo_en(tdo_en)
);

// File: tb/sim_jtag_sample_port.sv
`timescale 1ns/1ps
module sim_jtag_sample_port;
  localparam int          NPADS = 12;
  localparam logic [31:0] IDV   = 32'h1B6C_A0E3;

  logic             tck = 1'b0;
  logic             trst_n, tms, tdi;
  logic [NPADS-1:0] pads;
  logic             tdo, tdo_en;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  logic  exp_q[$];
  string tag_q[$];

  always #2 tck = ~tck;

  jtag_sample_port #(.NPADS(NPADS), .ID_VALUE(IDV)) u0 (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
    .pad_levels(pads), .tdo(tdo), .tdo_en(tdo_en)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: every shift cycle (tdo_en high) consumes one expected item.
  always @(posedge tck) begin
    if (tdo_en && !done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11 unexpected shift", {63'd0, tdo}, 64'd0);
      end else begin
        logic  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(tdo === e, t, {63'd0, tdo}, {63'd0, e});
      end
    end
  end

  task automatic step(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #0.5;
  endtask

  task automatic expect_bit(input logic b, input string tag);
    exp_q.push_back(b);
    tag_q.push_back(tag);
  endtask

  // From Run-Test/Idle, shift n instruction bits and return to idle.
  task automatic scan_ir(input int n, input logic [7:0] din, input logic [7:0] exp, input string tag);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin
      expect_bit(exp[i], tag);
      step(i == n - 1, din[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  // From Run-Test/Idle, shift n data bits, optionally pausing after k bits.
  task automatic scan_dr(input int n, input logic [63:0] din, input logic [63:0] exp,
                         input string tag, input int k);
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin
      expect_bit(exp[i], tag);
      step((i == n - 1) || (i == k - 1), din[i]);
      if (i == k - 1 && i != n - 1) begin
        step(0, 0); step(0, 0);
        check(tdo_en === 1'b0, "R8 enable low in Pause-DR", {63'd0, tdo_en}, 64'd0);
        step(1, 0); step(0, 0);
      end
    end
    step(1, 0);
    check(tdo_en === 1'b0 && tdo === 1'b0, "R8 quiet in Update-DR", {62'd0, tdo_en, tdo}, 64'd0);
    step(0, 0);
  endtask

  task automatic tms_reset();
    for (int i = 0; i < 5; i++) step(1, 0);
    step(0, 0);
  endtask

  initial begin
    #(200000 * 4);
    check(1'b0, "R11 watchdog expired", 64'd0, 64'd1);
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    trst_n = 1'b0; tms = 1'b1; tdi = 1'b0; pads = '0;
    @(negedge tck); #0.5;
    repeat (3) step(1, 0);
    check(tdo === 1'b0 && tdo_en === 1'b0, "R11 reset outputs", {62'd0, tdo_en, tdo}, 64'd0);
    trst_n = 1'b1;
    tms_reset();

    // R9 R2 R3: IDCODE is active after reset, read LSB first
    scan_dr(32, 64'd0, {32'd0, IDV}, "R2 R3 R9 idcode after reset", 0);

    // R7: capture pattern, then BYPASS
    scan_ir(3, 8'b111, 8'b001, "R7 capture pattern");
    // R1: bypass delays by one, first bit 0
    scan_dr(8, 64'hB2, {56'd0, 8'hB2 << 1}, "R1 bypass delay", 0);

    // R4 R3: SAMPLE captures pads
    pads = 12'hA5C;
    scan_ir(3, 8'b100, 8'b001, "R7 capture pattern");
    scan_dr(NPADS, 64'h3F0, {52'd0, 12'hA5C}, "R4 R3 sample pads", 0);
    // R8: update was a no-op; pause keeps position
    scan_dr(NPADS, 64'hFFF, {52'd0, 12'hA5C}, "R8 pause and resume", 5);

    // R5: SAMPLE-Z and EXTEST also use the boundary chain
    pads = 12'h3C9;
    scan_ir(3, 8'b010, 8'b001, "R7 capture pattern");
    scan_dr(NPADS, 64'd0, {52'd0, 12'h3C9}, "R5 sample-z chain", 0);
    pads = 12'h816;
    scan_ir(3, 8'b000, 8'b001, "R7 capture pattern");
    scan_dr(NPADS, 64'd0, {52'd0, 12'h816}, "R5 extest chain", 0);

    // R10: internal-test slot and unassigned codes fall back to bypass
    scan_ir(3, 8'b011, 8'b001, "R7 capture pattern");
    scan_dr(4, 64'h6, 64'hC, "R10 opcode 011 bypass", 0);
    scan_ir(3, 8'b101, 8'b001, "R7 capture pattern");
    scan_dr(5, 64'h13, 64'h6, "R10 opcode 101 bypass", 0);

    // R6: six-bit IR scan shows capture then shifted-in bits; last three stay
    pads = 12'h5A3;
    scan_ir(6, 8'b100_110, 8'b110_001, "R6 ir shift through");
    scan_dr(NPADS, 64'd0, {52'd0, 12'h5A3}, "R6 new instruction at update", 0);

    // R9: TMS reset returns to IDCODE
    scan_ir(3, 8'b111, 8'b001, "R7 capture pattern");
    tms_reset();
    scan_dr(32, 64'd0, {32'd0, IDV}, "R9 tms reset idcode", 0);

    // R9: asynchronous test reset returns to IDCODE
    scan_ir(3, 8'b111, 8'b001, "R7 capture pattern");
    tms = 1'b1;
    trst_n = 1'b0;
    #1;
    check(tdo_en === 1'b0, "R9 trst clears enable", {63'd0, tdo_en}, 64'd0);
    step(1, 0); step(1, 0);
    trst_n = 1'b1;
    tms_reset();
    scan_dr(32, 64'd0, {32'd0, IDV}, "R9 trst idcode", 0);

    check(exp_q.size() == 0, "R11 all expected bits shifted", exp_q.size(), 64'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule